// File: doc/BRIEF.md
# Aliased Multi-View Register File

This block is a register file whose storage can be reached through three overlapping register views: 32-bit single registers, 64-bit double registers and 128-bit quad registers. All three views land on one physical array of sixteen 128-bit quad slots. Two doubles make one quad, with the even double in the low half. Two singles make one double, with the even single in the low half. Only the lower half of the bank, doubles 0 to 15 (quads 0 to 7), can be reached by single registers.

Each access gives a view code and a 5-bit index. A write also gives right-aligned data. A write through a narrow view replaces only its own slice of the containing quad. A mode input cuts the bank down to sixteen doubles. An access that falls outside the bank, or that uses the reserved view code, is flagged. Such an access never touches storage.

The block has one write port with a registered error pulse and two independent combinational read ports. Each read port has its own error flag.

Top module: `arf_bank`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears the whole storage array, so every legal read afterwards returns zero.
- R2: Single register 2n reads and writes bits 31:0 of double n, and single 2n+1 reads and writes bits 63:32 of double n. Single indices 0 to 31 cover doubles 0 to 15 only.
- R3: Double register 2n is bits 63:0 of quad n, and double 2n+1 is bits 127:64 of quad n.
- R4: A write through a single or double view changes only the bits of that register. All other bits of the containing quad keep their values.
- R5: Read data is right-aligned on the 128-bit read output. Bits above the view width (above bit 31 for singles, above bit 63 for doubles) read as zero.
- R6: Quads 8 to 15 hold doubles 16 to 31 (quad 8 is doubles 16 and 17), and no single index reaches them.
- R7: With half_bank high, doubles 16 to 31 and quads 8 to 15 are illegal. A read of one of them returns zero with its error flag set.
- R8: The view code is 00 for single, 01 for double and 10 for quad. Code 11 is reserved, and it is illegal at any index.
- R9: An illegal write leaves all storage unchanged. It sets wr_err for exactly the one cycle after the edge that sampled it. A legal write clears wr_err on that edge.
- R10: Quad indices 16 to 31 are illegal in both bank modes.
- R11: A legal write becomes visible on both read ports right after the rising edge that samples it. The two read ports decode their view and index independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| half_bank | input | 1 | High limits the bank to doubles 0 to 15 |
| wr_en | input | 1 | Write request |
| wr_view | input | 2 | Write view code (00 single, 01 double, 10 quad, 11 reserved) |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 128 | Write data, right-aligned |
| wr_err | output | 1 | One-cycle pulse after an illegal write |
| ra_view | input | 2 | Read port A view code |
| ra_idx | input | 5 | Read port A register index |
| ra_data | output | 128 | Read port A data, right-aligned, zero-filled |
| ra_err | output | 1 | Read port A illegal access flag |
| rb_view | input | 2 | Read port B view code |
| rb_idx | input | 5 | Read port B register index |
| rb_data | output | 128 | Read port B data, right-aligned, zero-filled |
| rb_err | output | 1 | Read port B illegal access flag |

## Verification
Both read ports are combinational, so a stale or corrupted slot shows at the ports in the same cycle that any view of it is read. A write that lands on the wrong slice shows on the first read after the write edge. The bench sweeps every view and index on both ports after each phase of writes. A wrong alias decode therefore appears as a mismatch on a neighbouring single, double or quad, and a write mask that is too wide appears as damaged bits in the other half of a quad. A decode that treats an illegal access as legal shows up at once as non-zero data or a missing error flag. For writes it shows up one edge later in wr_err, and as changed data on the next sweep.

// File: rtl/arf_pkg.sv
// Shared constants and types of the aliased register file.
// Assumes the bank is built from quad slots that each hold two
// doubles and, in the lower half of the bank, four singles.
package arf_pkg;
    localparam int SW      = 32;               // single register width
    localparam int DW      = 2 * SW;           // double register width
    localparam int QW      = 2 * DW;           // quad register width
    localparam int QUADS   = 16;               // quad slots in the full bank
    localparam int IDX_W   = 5;                // register index width
    localparam int SLOT_W  = $clog2(QUADS);
    localparam int SHIFT_W = $clog2(QW);

    typedef enum logic [1:0] {
        VIEW_S   = 2'b00,
        VIEW_D   = 2'b01,
        VIEW_Q   = 2'b10,
        VIEW_RSV = 2'b11
    } view_e;

    // Where an access lands inside the quad array.
    typedef struct packed {
        logic               ok;     // legal access
        logic [SLOT_W-1:0]  slot;   // quad slot holding the register
        logic [SHIFT_W-1:0] shift;  // bit offset of the register in the slot
        logic [QW-1:0]      mask;   // right-aligned width mask of the view
    } loc_t;
endpackage

// File: rtl/arf_locate.sv
// Alias decoder: turns a view code, an index and the bank mode into
// a quad slot, a bit offset, a width mask and a legality bit.
// Assumes an index of IDX_W bits. Single indices always reach the lower half.
module arf_locate
    import arf_pkg::*;
(
    input  view_e             view,
    input  logic [IDX_W-1:0]  idx,
    input  logic              half_bank,
    output loc_t              loc
);
    localparam logic [QW-1:0] S_MASK = {{(QW-SW){1'b0}}, {SW{1'b1}}};
    localparam logic [QW-1:0] D_MASK = {{(QW-DW){1'b0}}, {DW{1'b1}}};
    localparam logic [QW-1:0] Q_MASK = {QW{1'b1}};
    localparam int S_PER_Q = QW / SW;
    localparam int D_PER_Q = QW / DW;
    localparam int S_SEL_W = $clog2(S_PER_Q);
    localparam int D_SEL_W = $clog2(D_PER_Q);

    logic [IDX_W-1:0] s_slot;
    logic [IDX_W-1:0] d_slot;

    // Slot numbers of the narrow views: drop the in-quad select bits.
    always_comb begin
        s_slot = idx >> S_SEL_W;
        d_slot = idx >> D_SEL_W;
    end

    // Decode the access according to its view.
    always_comb begin
        loc = '0;
        unique case (view)
            VIEW_S: begin
                loc.ok    = 1'b1;
                loc.slot  = SLOT_W'(s_slot);
                loc.shift = SHIFT_W'(32'(idx[S_SEL_W-1:0]) * SW);
                loc.mask  = S_MASK;
            end
            VIEW_D: begin
                loc.ok    = !(half_bank && idx[IDX_W-1]);
                loc.slot  = SLOT_W'(d_slot);
                loc.shift = SHIFT_W'(32'(idx[D_SEL_W-1:0]) * DW);
                loc.mask  = D_MASK;
            end
            VIEW_Q: begin
                loc.ok    = !idx[IDX_W-1] && !(half_bank && idx[IDX_W-2]);
                loc.slot  = idx[SLOT_W-1:0];
                loc.shift = '0;
                loc.mask  = Q_MASK;
            end
            default: begin
                loc.ok    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/arf_read.sv
// Combinational read port: selects the decoded slot, shifts the
// register down to bit 0 and clears every bit above its width.
// Assumes the decoder supplies a legality bit; an illegal access reads zero.
module arf_read
    import arf_pkg::*;
(
    input  logic [QUADS-1:0][QW-1:0] store,
    input  loc_t                     loc,
    output logic [QW-1:0]            data,
    output logic                     err
);
    // Extract and right-align the addressed register.
    always_comb begin
        if (loc.ok) data = (store[loc.slot] >> loc.shift) & loc.mask;
        else        data = '0;
        err = !loc.ok;
    end
endmodule

// File: rtl/arf_bank.sv
// Aliased register file top: one quad-slot array seen through single,
// double and quad views, one write port and two read ports.
// Assumes a synchronous active-low reset. Writes take effect at the
// rising edge, and a narrow write merges into its slot under a mask.
module arf_bank
    import arf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_bank,
    input  logic              wr_en,
    input  logic [1:0]        wr_view,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [QW-1:0]     wr_data,
    output logic              wr_err,
    input  logic [1:0]        ra_view,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [QW-1:0]     ra_data,
    output logic              ra_err,
    input  logic [1:0]        rb_view,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [QW-1:0]     rb_data,
    output logic              rb_err
);
    loc_t                     wloc;
    loc_t                     aloc;
    loc_t                     bloc;
    logic [QW-1:0]            mem [QUADS];
    logic [QUADS-1:0][QW-1:0] store;
    logic [QW-1:0]            wmask;
    logic [QW-1:0]            wbits;

    arf_locate u_wloc (.view(view_e'(wr_view)), .idx(wr_idx), .half_bank(half_bank), .loc(wloc));
    arf_locate u_aloc (.view(view_e'(ra_view)), .idx(ra_idx), .half_bank(half_bank), .loc(aloc));
    arf_locate u_bloc (.view(view_e'(rb_view)), .idx(rb_idx), .half_bank(half_bank), .loc(bloc));

    // Position the write mask and data at the register's offset.
    always_comb begin
        wmask = wloc.mask << wloc.shift;
        wbits = (wr_data & wloc.mask) << wloc.shift;
    end

    // One storage process per quad slot; only the addressed slot changes.
    for (genvar q = 0; q < QUADS; q++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[q] <= '0;
            else if (wr_en && wloc.ok && (wloc.slot == SLOT_W'(q)))
                mem[q] <= (mem[q] & ~wmask) | wbits;
        end
        assign store[q] = mem[q];
    end

    // Flag an illegal write for the cycle after it is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= wr_en && !wloc.ok;
    end

    arf_read u_rda (.store(store), .loc(aloc), .data(ra_data), .err(ra_err));
    arf_read u_rdb (.store(store), .loc(bloc), .data(rb_data), .err(rb_err));

    // R9
    rsv_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'b11) |=> wr_err);
    // R9
    bad_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && half_bank && wr_view == 2'b10 && wr_idx[IDX_W-2]) |=> $stable(store));
    // R7
    reduced_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_bank && ra_view == 2'b01 && ra_idx[IDX_W-1]) |-> (ra_err && ra_data == '0));
    // R5
    single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_view == 2'b00) |-> (ra_data[QW-1:SW] == '0));
    // R8
    rsv_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_view == 2'b11) |-> (rb_err && rb_data == '0));
    // R10
    quad_high_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_view == 2'b10 && rb_idx[IDX_W-1]) |-> rb_err);
endmodule

// File: tb/arf_bank_test.sv
module arf_bank_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         half_bank;
    logic         wr_en;
    logic [1:0]   wr_view;
    logic [4:0]   wr_idx;
    logic [127:0] wr_data;
    logic         wr_err;
    logic [1:0]   ra_view, rb_view;
    logic [4:0]   ra_idx, rb_idx;
    logic [127:0] ra_data, rb_data;
    logic         ra_err, rb_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [63:0] dm [32];
    logic [31:0] lf = 32'h1F2E3D4C;

    always #2 clk = ~clk;

    arf_bank uut (
        .clk(clk), .rst_n(rst_n), .half_bank(half_bank),
        .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
        .ra_view(ra_view), .ra_idx(ra_idx), .ra_data(ra_data), .ra_err(ra_err),
        .rb_view(rb_view), .rb_idx(rb_idx), .rb_data(rb_data), .rb_err(rb_err)
    );

    function automatic bit legal(input logic [1:0] v, input logic [4:0] i, input bit h);
        case (v)
            2'd0:    return 1'b1;
            2'd1:    return !(h && i >= 16);
            2'd2:    return (i < 16) && !(h && i >= 8);
            default: return 1'b0;
        endcase
    endfunction

    // Expected read value: error flag above 128 data bits.
    function automatic logic [128:0] expect_rd(input logic [1:0] v, input logic [4:0] i, input bit h);
        if (!legal(v, i, h)) return {1'b1, 128'b0};
        case (v)
            2'd0:    return {1'b0, 96'b0, (i % 2 == 1) ? dm[i / 2][63:32] : dm[i / 2][31:0]};
            2'd1:    return {1'b0, 64'b0, dm[i]};
            default: return {1'b0, dm[2 * i + 1], dm[2 * i]};
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] v, input logic [4:0] i, input bit h, input string dflt);
        if (v == 2'd3) return "R8";
        if (v == 2'd2 && i >= 16) return "R10";
        if (!legal(v, i, h)) return "R7";
        return dflt;
    endfunction

    task automatic check(input string tag, input logic [128:0] act, input logic [128:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    task automatic read_both(input logic [1:0] va, input logic [4:0] ia,
                             input logic [1:0] vb, input logic [4:0] ib, input string tag);
        @(negedge clk);
        ra_view = va; ra_idx = ia; rb_view = vb; rb_idx = ib;
        #1;
        check(tag_of(va, ia, half_bank, tag), {ra_err, ra_data}, expect_rd(va, ia, half_bank));
        check(tag_of(vb, ib, half_bank, tag), {rb_err, rb_data}, expect_rd(vb, ib, half_bank));
    endtask

    task automatic sweep(input string tag);
        for (int v = 0; v < 4; v++)
            for (int i = 0; i < 32; i++)
                read_both(2'(v), 5'(i), 2'(v), 5'(31 - i), tag);
    endtask

    task automatic write(input logic [1:0] v, input logic [4:0] i, input logic [127:0] d, input string tag);
        bit ok;
        ok = legal(v, i, half_bank);
        @(negedge clk);
        wr_view = v; wr_idx = i; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(ok ? tag : "R9", {128'b0, wr_err}, {128'b0, !ok});
        if (ok) begin
            case (v)
                2'd0: if (i % 2 == 1) dm[i / 2][63:32] = d[31:0]; else dm[i / 2][31:0] = d[31:0];
                2'd1: dm[i] = d[63:0];
                default: begin dm[2 * i] = d[63:0]; dm[2 * i + 1] = d[127:64]; end
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 32; k++) dm[k] = '0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; half_bank = 1'b0; wr_en = 1'b0;
        wr_view = '0; wr_idx = '0; wr_data = '0;
        ra_view = '0; ra_idx = '0; rb_view = '0; rb_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 32; k++) dm[k] = '0;

        // R1: everything reads zero after reset
        sweep("R1");

        // R2: fill every single, then read through all views
        for (int i = 0; i < 32; i++)
            write(2'd0, 5'(i), {96'hDEAD, 32'hC0DE_0000 | 32'(i * 257)}, "R2");
        sweep("R2");

        // R6: upper doubles and quad 8 aliasing
        for (int i = 16; i < 32; i++)
            write(2'd1, 5'(i), {64'hFFFF, 64'h1234_5678_0000_0000 | 64'(i)}, "R6");
        write(2'd2, 5'd8, {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444}, "R6");
        read_both(2'd1, 5'd16, 2'd1, 5'd17, "R6");
        check("R6", {1'b0, rb_data}, {1'b0, 64'b0, 64'hAAAA_BBBB_CCCC_DDDD});
        sweep("R6");

        // R3: quad writes, read back as doubles and singles
        for (int i = 0; i < 16; i++)
            write(2'd2, 5'(i), {32'(i), 32'h5A5A_0000, 32'(~i), 32'h0F0F_0000 | 32'(i)}, "R3");
        sweep("R3");

        // R4: narrow writes keep the rest of the quad
        write(2'd0, 5'd5, 128'h9999_8888_7777_6666_5555_4444_3333_2222, "R4");
        write(2'd1, 5'd3, 128'hFFFF_FFFF_FFFF_FFFF_0123_4567_89AB_CDEF, "R4");
        write(2'd1, 5'd24, 128'h0, "R4");
        read_both(2'd2, 5'd1, 2'd2, 5'd12, "R4");
        read_both(2'd0, 5'd4, 2'd0, 5'd7, "R5");
        sweep("R4");

        // R7 / R9: reduced bank rejects upper registers
        half_bank = 1'b1;
        sweep("R7");
        write(2'd1, 5'd20, 128'h0BAD, "R9");
        @(negedge clk);
        check("R9", {128'b0, wr_err}, 129'd0);
        write(2'd2, 5'd9, {128{1'b1}}, "R9");
        write(2'd3, 5'd2, {128{1'b1}}, "R8");
        write(2'd2, 5'd18, {128{1'b1}}, "R10");
        write(2'd1, 5'd2, 128'h7E57, "R11");
        @(negedge clk);
        check("R9", {128'b0, wr_err}, 129'd0);
        half_bank = 1'b0;
        sweep("R9");

        // R11: mixed random writes with reads on both ports
        for (int n = 0; n < 400; n++) begin
            logic [127:0] d;
            logic [1:0] v;
            logic [4:0] i;
            step_lf(); d[31:0] = lf; step_lf(); d[63:32] = lf;
            step_lf(); d[95:64] = lf; step_lf(); d[127:96] = lf;
            step_lf(); v = lf[1:0]; i = lf[8:4]; half_bank = lf[12];
            write(v, i, d, "R11");
            read_both(v, i, lf[17:16], lf[24:20], "R11");
        end
        half_bank = 1'b0;
        sweep("R11");

        // R1: reset after data clears storage again
        do_reset();
        sweep("R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule